// File: doc/BRIEF.md
# Prioritized External Interrupt Collector

This block gathers up to 32 asynchronous interrupt lines from outside the processor and presents them to the CPU as one interrupt request. Each line's trigger is fixed when the block is elaborated. It can be high-level, low-level, rising-edge or falling-edge. A line that triggers sets a sticky flag bit. A flag only counts toward the CPU request when its line is also unmasked.

The CPU request is taken in rounds. When no round is open and some unmasked flag is set, the block opens a round. It records the lowest-numbered candidate line as the round's identifier and raises the request. The request and the identifier then stay unchanged until software writes any value to the identifier word. That write closes the round. If unmasked flags are still set, the next round opens one cycle later.

Software reaches the block through four 32-bit words. It selects a word with a two-bit word index and uses separate read and write strobes. Reads are combinational. Writes take effect at the next clock edge.

Top module: `ext_irq_hub`

## Requirements
- R1: After synchronous reset, `cpu_irq` is 0 and every word reads 0 (mask, flags, identifier, spare).
- R2: An edge-triggered line sets its flag once per qualifying edge. Holding the line at its new level does not set the flag again after software clears it. An edge in the other direction does not set it.
- R3: A level-triggered line sets its flag on every clock edge while it sits at its active level, so a software clear does not stick until the line returns to its inactive level.
- R4: Writing word index 1 (flags) ANDs the written data into the flags. A 0 bit clears the flag. A 1 bit keeps the flag as it is and never sets it.
- R5: A set flag whose bit in word index 0 (mask, 1 = line enabled) is 0 never raises `cpu_irq`, and the flag stays set.
- R6: When a round opens, `cpu_irq` rises one clock after the flag and mask are both set. The identifier at word index 2, in bits 4:0, is the lowest line number that is both flagged and enabled. Line 0 wins over all others.
- R7: While a round is open, `cpu_irq` stays 1 and the identifier stays unchanged, even when a line with a higher priority becomes flagged.
- R8: A write of any value to word index 2 closes an open round. `cpu_irq` is 0 after that edge. One edge later, a new round opens if any enabled flag is still set.
- R9: When a trigger and a software clear of the same flag meet at one edge, the flag stays set.
- R10: Line numbers at or above `NUM_CH` are ignored. Their mask and flag bits read 0, and their inputs never raise `cpu_irq`.
- R11: Word index 3 always reads 0, and writes to it change no state.
- R12: A line input passes through two synchronizer flops. A trigger level or edge applied before a clock edge shows in the flag at the third clock edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 32 | External interrupt lines, line 0 in bit 0 |
| reg_word | input | 2 | Word index: 0 mask, 1 flags, 2 identifier/acknowledge, 3 spare |
| wr_en | input | 1 | Write strobe for the selected word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rd_data is 0 when low |
| rd_data | output | 32 | Read data for the selected word |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Every cycle, the assertions check four things. An open round keeps its request and its frozen identifier until acknowledged. An acknowledge drops the request at the next edge. A round only opens on an enabled flag, and it picks the lowest such line. The flag update never holds a bit that was neither kept by the write nor triggered, and it never loses a trigger.

The pin-level behaviour of the trigger cells can only be shown by the bench's scenarios. These cover the three-edge latency, one flag set per edge as opposed to a repeating level, the ignoring of opposite edges, and the exact cycle in which a trigger meets a clear. The bench also shows the ignored upper lines and the spare word at the ports.

// File: rtl/ext_irq_hub_pkg.sv
package ext_irq_hub_pkg;
   localparam int unsigned MAX_LINES = 32;
   localparam int unsigned ID_W      = 5;
   localparam int unsigned WORD_W    = 32;

   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_SRC  = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   typedef logic [MAX_LINES-1:0] line_vec_t;
endpackage

// File: rtl/eih_trig_cell.sv
// One line: two-flop synchronizer plus level or edge qualification.
module eih_trig_cell #(
   parameter bit EDGE_MODE  = 1'b1,
   parameter bit ACTIVE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   output logic hit_o
);
   localparam bit IDLE_LVL = ~ACTIVE_LVL;

   logic meta_q;
   logic sync_q;
   logic active;

   // Reset to the idle level so release from reset shows no false trigger.
   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q <= IDLE_LVL;
         sync_q <= IDLE_LVL;
      end else begin
         meta_q <= line_in;
         sync_q <= meta_q;
      end
   end

   assign active = (sync_q == ACTIVE_LVL);

   if (EDGE_MODE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
         if (rst) prev_q <= IDLE_LVL;
         else     prev_q <= sync_q;
      end
      assign hit_o = active && (prev_q != ACTIVE_LVL);
   end else begin : g_level
      assign hit_o = active;
   end
endmodule

// File: rtl/eih_prio_enc.sv
// Lowest index wins.
module eih_prio_enc #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned IDW   = 5
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             any_o,
   output logic [IDW-1:0]   id_o
);
   if (WIDTH > (1 << IDW)) begin : g_bad_width
      $error("eih_prio_enc: WIDTH does not fit in IDW bits");
   end

   always_comb begin
      any_o = |req_i;
      id_o  = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (req_i[i]) id_o = IDW'(i);
      end
   end
endmodule

// File: rtl/eih_flag_bank.sv
// Mask and sticky flag registers; trigger beats a clear.
module eih_flag_bank
   import ext_irq_hub_pkg::*;
#(
   parameter int unsigned NUM_CH = 32
) (
   input  logic      clk,
   input  logic      rst,
   input  line_vec_t hit_i,
   input  logic      mask_we,
   input  logic      flag_we,
   input  line_vec_t wdata,
   output line_vec_t mask_q,
   output line_vec_t flag_q
);
   localparam logic [63:0] LIVE64 = (64'd1 << NUM_CH) - 64'd1;
   localparam line_vec_t   LIVE   = LIVE64[MAX_LINES-1:0];

   line_vec_t keep;

   assign keep = flag_we ? wdata : '1;

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q <= '0;
         flag_q <= '0;
      end else begin
         if (mask_we) mask_q <= wdata & LIVE;
         flag_q <= ((flag_q & keep) | hit_i) & LIVE;
      end
   end
endmodule

// File: rtl/eih_req_ctrl.sv
// Round control: capture the winner, hold until acknowledge.
module eih_req_ctrl
   import ext_irq_hub_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic            cand_any,
   input  logic [ID_W-1:0] cand_id,
   input  logic            ack,
   output logic            busy_q,
   output logic [ID_W-1:0] src_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         src_q  <= '0;
      end else if (busy_q) begin
         if (ack) busy_q <= 1'b0;
      end else if (cand_any) begin
         busy_q <= 1'b1;
         src_q  <= cand_id;
      end
   end
endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub
   import ext_irq_hub_pkg::*;
#(
   parameter int unsigned      NUM_CH   = 32,
   parameter logic [31:0]      EDGE_SEL = 32'hFFFF_FFFF,
   parameter logic [31:0]      ACT_HIGH = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [31:0] irq_in,
   input  logic [1:0]  reg_word,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        rd_en,
   output logic [31:0] rd_data,
   output logic        cpu_irq
);
   if (NUM_CH > MAX_LINES) begin : g_bad_count
      $error("ext_irq_hub: NUM_CH must be 0..32");
   end

   reg_sel_e        sel;
   line_vec_t       hit;
   line_vec_t       mask_q;
   line_vec_t       flag_q;
   line_vec_t       cand;
   logic            cand_any;
   logic [ID_W-1:0] cand_id;
   logic [ID_W-1:0] src_q;
   logic            busy_q;
   logic            ack;

   assign sel = reg_sel_e'(reg_word);

   for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
      if (i < NUM_CH) begin : g_used
         eih_trig_cell #(
            .EDGE_MODE (EDGE_SEL[i]),
            .ACTIVE_LVL(ACT_HIGH[i])
         ) cell_i (
            .clk    (clk),
            .rst    (rst),
            .line_in(irq_in[i]),
            .hit_o  (hit[i])
         );
      end else begin : g_unused
         assign hit[i] = 1'b0;
      end
   end

   eih_flag_bank #(.NUM_CH(NUM_CH)) bank_i (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit),
      .mask_we(wr_en && (sel == SEL_MASK)),
      .flag_we(wr_en && (sel == SEL_FLAG)),
      .wdata  (wr_data),
      .mask_q (mask_q),
      .flag_q (flag_q)
   );

   assign cand = mask_q & flag_q;

   eih_prio_enc #(.WIDTH(MAX_LINES), .IDW(ID_W)) enc_i (
      .req_i(cand),
      .any_o(cand_any),
      .id_o (cand_id)
   );

   assign ack = wr_en && (sel == SEL_SRC);

   eih_req_ctrl ctrl_i (
      .clk     (clk),
      .rst     (rst),
      .cand_any(cand_any),
      .cand_id (cand_id),
      .ack     (ack),
      .busy_q  (busy_q),
      .src_q   (src_q)
   );

   assign cpu_irq = busy_q;

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         unique case (sel)
            SEL_MASK: rd_data = mask_q;
            SEL_FLAG: rd_data = flag_q;
            SEL_SRC:  rd_data = {{(WORD_W-ID_W){1'b0}}, src_q};
            SEL_RSVD: rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/ext_irq_hub_chk.sv
module ext_irq_hub_chk #(
   parameter int unsigned NUM_CH = 32
) (
   input logic        clk,
   input logic        rst,
   input logic        cpu_irq,
   input logic [4:0]  src_id,
   input logic [31:0] mask_q,
   input logic [31:0] flag_q,
   input logic [31:0] hit,
   input logic        wr_en,
   input logic [1:0]  reg_word,
   input logic [31:0] wr_data,
   input logic        rd_en,
   input logic [31:0] rd_data
);
   localparam logic [63:0] LIVE64 = (64'd1 << NUM_CH) - 64'd1;
   localparam logic [31:0] LIVE   = LIVE64[31:0];

   logic        ack;
   logic        flag_we;
   logic [31:0] below_src;

   assign ack       = wr_en && (reg_word == 2'd2);
   assign flag_we   = wr_en && (reg_word == 2'd1);
   assign below_src = (32'd1 << src_id) - 32'd1;

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      cpu_irq && !ack |=> cpu_irq && $stable(src_id));

   p_ack_drop_r8: assert property (@(posedge clk) disable iff (rst)
      cpu_irq && ack |=> !cpu_irq);

   p_no_cause_r5: assert property (@(posedge clk) disable iff (rst)
      !cpu_irq && ((mask_q & flag_q) == 32'd0) |=> !cpu_irq);

   p_winner_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(cpu_irq) |-> ((($past(mask_q & flag_q) & below_src) == 32'd0)
                          && ((($past(mask_q & flag_q) >> src_id) & 32'd1) == 32'd1)));

   p_trig_wins_r9: assert property (@(posedge clk) disable iff (rst)
      (hit != 32'd0) |=> ((flag_q & $past(hit)) == $past(hit)));

   p_clear_only_r4: assert property (@(posedge clk) disable iff (rst)
      flag_we |=> ((flag_q & ~(($past(flag_q) & $past(wr_data)) | $past(hit))) == 32'd0));

   p_unused_r10: assert property (@(posedge clk) disable iff (rst)
      rd_en && (reg_word <= 2'd1) |-> ((rd_data & ~LIVE) == 32'd0));

   p_spare_r11: assert property (@(posedge clk) disable iff (rst)
      rd_en && (reg_word == 2'd3) |-> (rd_data == 32'd0));
endmodule

bind ext_irq_hub ext_irq_hub_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk     (clk),
   .rst     (rst),
   .cpu_irq (cpu_irq),
   .src_id  (src_q),
   .mask_q  (mask_q),
   .flag_q  (flag_q),
   .hit     (hit),
   .wr_en   (wr_en),
   .reg_word(reg_word),
   .wr_data (wr_data),
   .rd_en   (rd_en),
   .rd_data (rd_data)
);

// File: tb/ext_irq_hub_tb_top.sv
module ext_irq_hub_tb_top;
   // lines: 0 rising, 1 falling, 2 high level, 3 low level, 4/5 rising
   localparam int unsigned N_CH  = 6;
   localparam logic [31:0] EDGES = 32'h0000_0033;
   localparam logic [31:0] POLS  = 32'h0000_0035;
   localparam logic [1:0]  W_MASK = 2'd0, W_FLAG = 2'd1, W_SRC = 2'd2, W_RSVD = 2'd3;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] irq_in;
   logic [1:0]  reg_word;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        rd_en;
   logic [31:0] rd_data;
   logic        cpu_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   ext_irq_hub #(.NUM_CH(N_CH), .EDGE_SEL(EDGES), .ACT_HIGH(POLS)) dut_i (
      .clk(clk), .rst(rst), .irq_in(irq_in), .reg_word(reg_word), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .cpu_irq(cpu_irq)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] w, input logic [31:0] d);
      reg_word = w; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic expect_word(input logic [1:0] w, input logic [31:0] exp, input string req);
      logic [31:0] v;
      reg_word = w; rd_en = 1'b1;
      #1;
      v = rd_data;
      rd_en = 1'b0;
      chk(v == exp, req, v, exp);
   endtask

   task automatic expect_irq(input logic exp, input string req);
      chk(cpu_irq == exp, req, {31'd0, cpu_irq}, {31'd0, exp});
   endtask

   task automatic t_reset;
      expect_irq(1'b0, "R1 irq");
      expect_word(W_MASK, 32'h0, "R1 mask");
      expect_word(W_FLAG, 32'h0, "R1 flag");
      expect_word(W_SRC,  32'h0, "R1 src");
      expect_word(W_RSVD, 32'h0, "R1 spare");
   endtask

   task automatic t_latency;
      irq_in[0] = 1'b1;
      cyc(2);
      expect_word(W_FLAG, 32'h0, "R12 not before third edge");
      cyc(1);
      expect_word(W_FLAG, 32'h1, "R12 at third edge");
   endtask

   task automatic t_edge;
      wr(W_FLAG, 32'h0);
      cyc(4);
      expect_word(W_FLAG, 32'h0, "R2 held high no retrigger");
      irq_in[1] = 1'b0;
      cyc(3);
      expect_word(W_FLAG, 32'h2, "R2 falling edge");
      cyc(3);
      expect_word(W_FLAG, 32'h2, "R2 single set");
      irq_in[1] = 1'b1;
      irq_in[0] = 1'b0;
      cyc(4);
      expect_word(W_FLAG, 32'h2, "R2 opposite edges ignored");
      wr(W_FLAG, 32'h0);
   endtask

   task automatic t_level;
      irq_in[2] = 1'b1;
      cyc(3);
      expect_word(W_FLAG, 32'h4, "R3 high level sets");
      wr(W_FLAG, 32'h0);
      expect_word(W_FLAG, 32'h4, "R3 clear does not stick");
      irq_in[2] = 1'b0;
      cyc(3);
      wr(W_FLAG, 32'h0);
      expect_word(W_FLAG, 32'h0, "R3 clear after release");
      irq_in[3] = 1'b0;
      cyc(3);
      expect_word(W_FLAG, 32'h8, "R3 low level sets");
      irq_in[3] = 1'b1;
      cyc(3);
      wr(W_FLAG, 32'h0);
      expect_word(W_FLAG, 32'h0, "R3 low level released");
   endtask

   task automatic t_clear;
      irq_in[1] = 1'b0;
      irq_in[4] = 1'b1;
      cyc(3);
      expect_word(W_FLAG, 32'h12, "R4 setup");
      wr(W_FLAG, 32'hFFFF_FFFF);
      expect_word(W_FLAG, 32'h12, "R4 ones keep and never set");
      wr(W_FLAG, 32'h10);
      expect_word(W_FLAG, 32'h10, "R4 partial clear");
      irq_in[1] = 1'b1;
   endtask

   task automatic t_masked;
      cyc(4);
      expect_irq(1'b0, "R5 masked no irq");
      expect_word(W_FLAG, 32'h10, "R5 stays flagged");
   endtask

   task automatic t_round;
      irq_in[1] = 1'b0;
      cyc(3);
      expect_word(W_FLAG, 32'h12, "R6 two flagged");
      wr(W_MASK, 32'hFFFF_FFFF);
      expect_word(W_MASK, 32'h3F, "R10 upper mask bits read 0");
      expect_irq(1'b0, "R6 not same edge as mask");
      cyc(1);
      expect_irq(1'b1, "R6 irq raised");
      expect_word(W_SRC, 32'h1, "R6 lowest line wins");
      irq_in[0] = 1'b1;
      cyc(3);
      expect_word(W_FLAG, 32'h13, "R7 line 0 flagged");
      expect_irq(1'b1, "R7 irq held");
      expect_word(W_SRC, 32'h1, "R7 id frozen");
   endtask

   task automatic t_ack;
      wr(W_SRC, 32'hDEAD_BEEF);
      expect_irq(1'b0, "R8 dropped after ack");
      cyc(1);
      expect_irq(1'b1, "R8 new round");
      expect_word(W_SRC, 32'h0, "R8 line 0 now wins");
      wr(W_FLAG, 32'h0);
      wr(W_SRC, 32'h0);
      expect_irq(1'b0, "R8 ack with nothing left");
      cyc(3);
      expect_irq(1'b0, "R8 stays idle");
   endtask

   task automatic t_race;
      wr(W_MASK, 32'h0);
      irq_in[5] = 1'b1;
      cyc(2);
      wr(W_FLAG, 32'h0);
      expect_word(W_FLAG, 32'h20, "R9 trigger beats clear");
      wr(W_FLAG, 32'h0);
      expect_word(W_FLAG, 32'h0, "R9 later clear works");
   endtask

   task automatic t_unused;
      wr(W_MASK, 32'hFFFF_FFFF);
      irq_in[31:6] = '1;
      cyc(4);
      expect_word(W_FLAG, 32'h0, "R10 upper lines ignored");
      expect_irq(1'b0, "R10 no irq from upper lines");
      wr(W_FLAG, 32'hFFFF_FFFF);
      expect_word(W_FLAG, 32'h0, "R10 flags not settable");
   endtask

   task automatic t_spare;
      wr(W_RSVD, 32'hFFFF_FFFF);
      expect_word(W_RSVD, 32'h0, "R11 spare reads 0");
      expect_word(W_MASK, 32'h3F, "R11 mask unchanged");
      expect_word(W_FLAG, 32'h0, "R11 flags unchanged");
      expect_irq(1'b0, "R11 no irq");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      irq_in = 32'h0000_000A;
      reg_word = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
      cyc(4);
      rst = 1'b0;
      cyc(1);
      t_reset();
      t_latency();
      t_edge();
      t_level();
      t_clear();
      t_masked();
      t_round();
      t_ack();
      t_race();
      t_unused();
      t_spare();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule